// File: doc/BRIEF.md
# Dual-Thread Fetch Decoupling Buffer

This block sits between instruction fetch and instruction decode in a core that runs two hardware threads side by side. Fetch hands it aligned groups of eight 32-bit instructions, each group tagged with the thread it belongs to. Decode pulls up to four instructions per cycle from a single thread and receives them in a registered decode slot, oldest first. Because a group is twice the width of the read port, fetch can run ahead of decode. The buffer absorbs that difference in both directions. Fetch keeps filling while decode stalls, and decode keeps draining while fetch pauses.

The capacity is 64 instructions. While both threads are active, each thread may hold at most half of it. While only one thread is active, that thread may use all of it. Each thread can be flushed on its own, for example after a mispredicted branch, and the flush leaves the other thread untouched. When both threads have instructions ready, the read side takes them in turn, one thread per cycle.

Top module: `fetch_decouple_buf`

## Requirements
- R1: After reset, dec_valid is 0, thr_nonempty is 0, thr_full is 0, and grp_ready is 1 for every active thread.
- R2: grp_ready[t] is 1 only when all of these hold: thread t is active (thr_active[t]), thr_flush[t] is low, thread t's count plus 8 does not exceed its share limit, and the total count plus 8 does not exceed 64. A group is stored when grp_valid is high and grp_ready[grp_tid] is high. An inactive thread never takes a group, but it still drains.
- R3: The share limit is 32 instructions per thread when thr_active is 2'b11, and 64 otherwise. The total held by both threads never exceeds 64.
- R4: Instruction i of a group is grp_data[32*i+31:32*i], and slot 0 is the oldest. The decode slots use the same layout (dec_data[32*j+31:32*j]), and each thread's instructions leave in the exact order they were written.
- R5: A read takes min(4, count) instructions from the chosen thread. dec_valid is a thermometer mask: bit j is set exactly when slot j holds an instruction.
- R6: A thread can be read when it holds instructions and is not being flushed. If both threads can be read, the thread not read last is chosen, so reads alternate each cycle. After reset, thread 0 wins the first tie. dec_tid names the thread that owns the slots.
- R7: While dec_stall is high, nothing is removed and the decode slot holds its contents. Fetch writes are still accepted until the thread's share is full.
- R8: When thr_flush[t] is high, thread t is emptied at the next edge, and any group written to t in that cycle is dropped. The other thread is not disturbed. If the decode slot holds thread t's instructions during a stall, dec_valid is cleared.
- R9: After thr_active changes, a thread whose count is above its new limit minus 8 gets no writes. It stays blocked until decode has drained it to that level.
- R10: thr_nonempty[t] is 1 when thread t holds any instruction. thr_full[t] is 1 when thread t's count plus 8 exceeds its share limit.
- R11: A group written at clock edge k can appear in the decode slot at edge k+1 at the earliest, so it is visible after two edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_active | input | 2 | Per-thread active flags |
| grp_valid | input | 1 | A fetch group is offered |
| grp_tid | input | 1 | Thread of the offered group |
| grp_data | input | 256 | Eight instructions, slot 0 oldest |
| grp_ready | output | 2 | Per-thread write acceptance |
| thr_flush | input | 2 | Per-thread flush |
| dec_stall | input | 1 | Decode cannot take new slots |
| dec_valid | output | 4 | Thermometer mask of valid decode slots |
| dec_tid | output | 1 | Thread owning the decode slots |
| dec_data | output | 128 | Four decode slots, slot 0 oldest |
| thr_nonempty | output | 2 | Thread holds instructions |
| thr_full | output | 2 | Thread has no room for a group |

## Verification
A wrong read or write pointer shows up at dec_data within two edges of the first read of that thread, as instructions out of order or as wrong values. A wrong count shows up in the very next cycle on thr_full, thr_nonempty or grp_ready, and a count that is wrong later shows up as a mask on dec_valid that is too short or too long. A wrong turn-taking state shows up as a repeated dec_tid while both threads hold data. A flush that leaks into the other thread shows up as a missing instruction there the next time that thread is read.

// File: rtl/ftq_pkg.sv
package ftq_pkg;

  // Per-thread share limit: half when both threads run, whole buffer otherwise.
  function automatic int unsigned share_limit(input logic both_on, input int unsigned depth);
    return both_on ? depth / 2 : depth;
  endfunction

  // Number of instructions one read removes.
  function automatic int unsigned take_count(input int unsigned held, input int unsigned port_w);
    return (held < port_w) ? held : port_w;
  endfunction

  // Thread choice: alternate on a tie, otherwise the only eligible one.
  function automatic logic choose_thread(input logic el0, input logic el1, input logic last);
    if (el0 && el1) return ~last;
    return el1 && !el0;
  endfunction

  // Thermometer mask with the lowest n bits set.
  function automatic logic [31:0] fill_mask(input int unsigned n);
    logic [31:0] m;
    for (int i = 0; i < 32; i++) m[i] = (i < n);
    return m;
  endfunction

endpackage

// File: rtl/ftq_lane.sv
module ftq_lane #(
  parameter int DEPTH = 64,
  parameter int IW    = 32,
  parameter int WR_N  = 8,
  parameter int RD_N  = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           push,
  input  logic [WR_N*IW-1:0]             push_data,
  input  logic [$clog2(RD_N+1)-1:0]      pop_n,
  input  logic                           flush,
  output logic [$clog2(DEPTH+1)-1:0]     cnt,
  output logic [RD_N*IW-1:0]             peek_data
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [IW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else if (flush) begin
      rptr <= wptr;
      cnt  <= '0;
    end else begin
      rptr <= rptr + AW'(pop_n);
      wptr <= wptr + (push ? AW'(WR_N) : AW'(0));
      cnt  <= cnt + (push ? CW'(WR_N) : CW'(0)) - CW'(pop_n);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) begin
      for (int i = 0; i < WR_N; i++) mem[wptr + AW'(i)] <= push_data[i*IW +: IW];
    end
  end

  for (genvar j = 0; j < RD_N; j++) begin : g_peek
    assign peek_data[j*IW +: IW] = mem[rptr + AW'(j)];
  end

  // R8: a flushed lane is empty at the following edge
  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt == '0));

  // R5: a read never asks for more than the lane holds
  assert_pop_within_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (CW'(pop_n) <= cnt));

  // R3: a lane never exceeds the whole capacity
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt <= CW'(DEPTH)));

endmodule

// File: rtl/ftq_pick.sv
module ftq_pick #(
  parameter int CW   = 7,
  parameter int PW   = 3,
  parameter int RD_N = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_a,
  input  logic [CW-1:0] cnt_b,
  input  logic [1:0]    flush,
  input  logic          stall,
  output logic          pick_en,
  output logic          pick_tid,
  output logic [PW-1:0] take
);
  import ftq_pkg::*;

  logic       last_q, armed_q;
  logic [1:0] elig;
  logic       both_elig;

  assign elig[0]   = (cnt_a != '0) && !flush[0];
  assign elig[1]   = (cnt_b != '0) && !flush[1];
  assign both_elig = &elig;
  assign pick_en   = !stall && (|elig);
  assign pick_tid  = choose_thread(elig[0], elig[1], last_q);
  assign take      = pick_en ? PW'(take_count(int'(pick_tid ? cnt_b : cnt_a), RD_N)) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q  <= 1'b1;
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      if (pick_en) last_q <= pick_tid;
    end
  end

  // R6: back-to-back reads with both threads eligible switch thread
  assert_alternate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(pick_en) && pick_en && both_elig |-> (pick_tid != $past(pick_tid)));

  // R6: a chosen thread is always an eligible one
  assert_pick_eligible_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pick_en |-> elig[pick_tid]);

endmodule

// File: rtl/fetch_decouple_buf.sv
module fetch_decouple_buf #(
  parameter int DEPTH = 64,
  parameter int IW    = 32,
  parameter int WR_N  = 8,
  parameter int RD_N  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         thr_active,
  input  logic               grp_valid,
  input  logic               grp_tid,
  input  logic [WR_N*IW-1:0] grp_data,
  output logic [1:0]         grp_ready,
  input  logic [1:0]         thr_flush,
  input  logic               dec_stall,
  output logic [RD_N-1:0]    dec_valid,
  output logic               dec_tid,
  output logic [RD_N*IW-1:0] dec_data,
  output logic [1:0]         thr_nonempty,
  output logic [1:0]         thr_full
);
  import ftq_pkg::*;

  localparam int CW   = $clog2(DEPTH + 1);
  localparam int PW   = $clog2(RD_N + 1);
  localparam int TW   = CW + 1;
  localparam int HALF = DEPTH / 2;

  logic [CW-1:0]      cnt  [2];
  logic [RD_N*IW-1:0] peek [2];
  logic [PW-1:0]      pop_n [2];
  logic [1:0]         push, room;
  logic               both_on, total_room, pick_en, pick_tid, armed_q;
  logic [CW-1:0]      lim;
  logic [TW-1:0]      total;
  logic [PW-1:0]      take;
  logic [31:0]        mask_w;

  assign both_on    = &thr_active;
  assign lim        = CW'(share_limit(both_on, DEPTH));
  assign total      = TW'(cnt[0]) + TW'(cnt[1]);
  assign total_room = (total + TW'(WR_N)) <= TW'(DEPTH);

  for (genvar t = 0; t < 2; t++) begin : g_thr
    assign room[t]         = (TW'(cnt[t]) + TW'(WR_N)) <= TW'(lim);
    assign grp_ready[t]    = thr_active[t] && !thr_flush[t] && room[t] && total_room;
    assign push[t]         = grp_valid && (grp_tid == 1'(t)) && grp_ready[t];
    assign pop_n[t]        = (pick_en && (pick_tid == 1'(t))) ? take : '0;
    assign thr_full[t]     = !room[t];
    assign thr_nonempty[t] = (cnt[t] != '0);

    ftq_lane #(.DEPTH(DEPTH), .IW(IW), .WR_N(WR_N), .RD_N(RD_N)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push[t]),
      .push_data (grp_data),
      .pop_n     (pop_n[t]),
      .flush     (thr_flush[t]),
      .cnt       (cnt[t]),
      .peek_data (peek[t])
    );

    // R3: with both threads running and the share already respected, it stays respected
    assert_share_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q && both_on && $past(both_on) && ($past(cnt[t]) <= CW'(HALF)) |-> (cnt[t] <= CW'(HALF)));
  end

  ftq_pick #(.CW(CW), .PW(PW), .RD_N(RD_N)) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_a    (cnt[0]),
    .cnt_b    (cnt[1]),
    .flush    (thr_flush),
    .stall    (dec_stall),
    .pick_en  (pick_en),
    .pick_tid (pick_tid),
    .take     (take)
  );

  assign mask_w = fill_mask(int'(take));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid <= '0;
      dec_tid   <= 1'b0;
      dec_data  <= '0;
      armed_q   <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      if (!dec_stall) begin
        dec_valid <= mask_w[RD_N-1:0];
        dec_tid   <= pick_tid;
        dec_data  <= peek[pick_tid];
      end else if (thr_flush[dec_tid]) begin
        dec_valid <= '0;
      end
    end
  end

  // R3: the two threads together never exceed the capacity
  assert_total_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (total <= TW'(DEPTH)));

  // R5: valid slots are packed from slot 0
  assert_thermo_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((dec_valid & (dec_valid + RD_N'(1))) == '0));

  // R7: a stalled decode slot holds its contents when no flush is applied
  assert_hold_on_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_stall && !(|thr_flush) |=> $stable(dec_valid) && $stable(dec_data) && $stable(dec_tid));

  // R2: no group lands in an inactive thread
  assert_no_write_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    grp_valid && !thr_active[grp_tid] |=> ($past(cnt[grp_tid]) >= cnt[grp_tid]) || $past(grp_tid) != grp_tid);

endmodule

// File: tb/fetch_decouple_buf_test.sv
module fetch_decouple_buf_test;
  localparam int DEPTH = 64;
  localparam int IW    = 32;
  localparam int WR_N  = 8;
  localparam int RD_N  = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic               rst_n;
  logic [1:0]         thr_active;
  logic               grp_valid;
  logic               grp_tid;
  logic [WR_N*IW-1:0] grp_data;
  logic [1:0]         grp_ready;
  logic [1:0]         thr_flush;
  logic               dec_stall;
  logic [RD_N-1:0]    dec_valid;
  logic               dec_tid;
  logic [RD_N*IW-1:0] dec_data;
  logic [1:0]         thr_nonempty;
  logic [1:0]         thr_full;

  fetch_decouple_buf #(.DEPTH(DEPTH), .IW(IW), .WR_N(WR_N), .RD_N(RD_N)) uut (
    .clk(clk), .rst_n(rst_n), .thr_active(thr_active), .grp_valid(grp_valid),
    .grp_tid(grp_tid), .grp_data(grp_data), .grp_ready(grp_ready), .thr_flush(thr_flush),
    .dec_stall(dec_stall), .dec_valid(dec_valid), .dec_tid(dec_tid), .dec_data(dec_data),
    .thr_nonempty(thr_nonempty), .thr_full(thr_full)
  );

  // Reference model state
  int unsigned     mq [2][$];
  logic            m_last;
  logic [RD_N-1:0] e_valid;
  logic            e_tid;
  logic [IW-1:0]   e_data [RD_N];

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int lim_of(input logic [1:0] act);
    return (&act) ? DEPTH / 2 : DEPTH;
  endfunction

  function automatic logic exp_ready(input int t);
    int tot;
    tot = mq[0].size() + mq[1].size();
    return thr_active[t] && !thr_flush[t] && (mq[t].size() + WR_N <= lim_of(thr_active))
           && (tot + WR_N <= DEPTH);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mq[0].delete();
      mq[1].delete();
      m_last  = 1'b1;
      e_valid = '0;
      e_tid   = 1'b0;
    end else begin
      int c[2];
      bit rdy[2];
      bit el[2];
      bit wr;
      int p;
      int n;
      c[0] = mq[0].size();
      c[1] = mq[1].size();
      for (int t = 0; t < 2; t++) rdy[t] = exp_ready(t);
      wr = grp_valid && rdy[int'(grp_tid)];
      n = 0;
      p = 0;
      if (!dec_stall) begin
        el[0] = (c[0] > 0) && !thr_flush[0];
        el[1] = (c[1] > 0) && !thr_flush[1];
        if (el[0] && el[1]) p = int'(!m_last);
        else p = el[1] ? 1 : 0;
        if (el[0] || el[1]) n = (c[p] < RD_N) ? c[p] : RD_N;
        for (int i = 0; i < RD_N; i++) begin
          e_valid[i] = (i < n);
          if (i < n) e_data[i] = mq[p][i];
        end
        e_tid = 1'(p);
        if (n > 0) m_last = 1'(p);
      end else if (thr_flush[e_tid]) begin
        e_valid = '0;
      end
      for (int t = 0; t < 2; t++) begin
        if (thr_flush[t]) mq[t].delete();
        else if (n > 0 && t == p) for (int i = 0; i < n; i++) void'(mq[t].pop_front());
      end
      if (wr) for (int i = 0; i < WR_N; i++) mq[int'(grp_tid)].push_back(grp_data[i*IW +: IW]);
    end
  end

  task automatic cmp_regs();
    chk(dec_valid === e_valid, "R5 valid mask", 64'(dec_valid), 64'(e_valid));
    for (int i = 0; i < RD_N; i++)
      if (e_valid[i]) chk(dec_data[i*IW +: IW] === e_data[i], "R4 slot order/data",
                          64'(dec_data[i*IW +: IW]), 64'(e_data[i]));
    if (|e_valid) chk(dec_tid === e_tid, "R6 read thread", 64'(dec_tid), 64'(e_tid));
  endtask

  task automatic cmp_comb();
    for (int t = 0; t < 2; t++) begin
      chk(grp_ready[t] === exp_ready(t), "R2 R9 write ready", 64'(grp_ready[t]), 64'(exp_ready(t)));
      chk(thr_full[t] === (mq[t].size() + WR_N > lim_of(thr_active)), "R10 full",
          64'(thr_full[t]), 64'(mq[t].size() + WR_N > lim_of(thr_active)));
      chk(thr_nonempty[t] === (mq[t].size() > 0), "R10 nonempty",
          64'(thr_nonempty[t]), 64'(mq[t].size() > 0));
    end
  endtask

  task automatic step(input logic [1:0] act, input logic v, input logic tid,
                      input logic [1:0] fl, input logic st);
    @(negedge clk);
    cmp_regs();
    thr_active = act;
    grp_valid  = v;
    grp_tid    = tid;
    thr_flush  = fl;
    dec_stall  = st;
    for (int i = 0; i < WR_N; i++) grp_data[i*IW +: IW] = $urandom;
    #1;
    cmp_comb();
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog R11 actual=hang expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic       x;
    logic       t1, t2;
    logic [RD_N*IW-1:0] held;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; thr_active = 2'b11; grp_valid = 1'b0; grp_tid = 1'b0;
    grp_data = '0; thr_flush = 2'b00; dec_stall = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(dec_valid === '0, "R1 reset valid", 64'(dec_valid), 64'h0);
    chk(thr_nonempty === 2'b00, "R1 reset nonempty", 64'(thr_nonempty), 64'h0);
    chk(thr_full === 2'b00, "R1 reset full", 64'(thr_full), 64'h0);
    chk(grp_ready === 2'b11, "R1 reset ready", 64'(grp_ready), 64'h3);
    rst_n = 1'b1;

    // R3/R7: single thread fills all 64 while decode stalls
    for (int k = 0; k < 9; k++) step(2'b01, 1'b1, 1'b0, 2'b00, 1'b1);
    chk(grp_ready[0] === 1'b0, "R3 single-thread full at 64", 64'(grp_ready[0]), 64'h0);
    chk(thr_full[0] === 1'b1, "R3 full flag", 64'(thr_full[0]), 64'h1);
    chk(dec_valid === '0, "R7 stalled decode stays empty", 64'(dec_valid), 64'h0);

    // R9: switch to two threads, thread 0 above its new share
    step(2'b11, 1'b1, 1'b0, 2'b00, 1'b0);
    chk(grp_ready[0] === 1'b0, "R9 blocked after mode change", 64'(grp_ready[0]), 64'h0);
    chk(grp_ready[1] === 1'b0, "R9 total capacity blocks thread 1", 64'(grp_ready[1]), 64'h0);
    for (int k = 0; k < 14; k++) step(2'b11, 1'b1, 1'b0, 2'b00, 1'b0);

    // R11: latency from write to decode slot
    step(2'b11, 1'b0, 1'b0, 2'b11, 1'b0);
    step(2'b11, 1'b0, 1'b0, 2'b00, 1'b0);
    step(2'b11, 1'b1, 1'b0, 2'b00, 1'b0);
    step(2'b11, 1'b0, 1'b0, 2'b00, 1'b0);
    chk(dec_valid === '0, "R11 not visible after one edge", 64'(dec_valid), 64'h0);
    step(2'b11, 1'b0, 1'b0, 2'b00, 1'b0);
    chk(dec_valid === 4'hF, "R11 visible after two edges", 64'(dec_valid), 64'hF);
    step(2'b11, 1'b0, 1'b0, 2'b00, 1'b0);

    // R6: alternation with both threads loaded
    step(2'b11, 1'b1, 1'b0, 2'b00, 1'b1);
    step(2'b11, 1'b1, 1'b1, 2'b00, 1'b1);
    step(2'b11, 1'b0, 1'b0, 2'b00, 1'b0);
    step(2'b11, 1'b0, 1'b0, 2'b00, 1'b0);
    t1 = dec_tid;
    for (int k = 0; k < 3; k++) begin
      step(2'b11, 1'b0, 1'b0, 2'b00, 1'b0);
      t2 = dec_tid;
      chk(t2 !== t1, "R6 thread alternates", 64'(t2), 64'(!t1));
      chk(dec_valid === 4'hF, "R5 four slots per read", 64'(dec_valid), 64'hF);
      t1 = t2;
    end
    for (int k = 0; k < 3; k++) step(2'b11, 1'b0, 1'b0, 2'b00, 1'b0);

    // R7/R8: stall holds the slot, flush of its owner clears it only
    step(2'b11, 1'b1, 1'b0, 2'b00, 1'b1);
    step(2'b11, 1'b1, 1'b1, 2'b00, 1'b1);
    step(2'b11, 1'b0, 1'b0, 2'b00, 1'b0);
    step(2'b11, 1'b0, 1'b0, 2'b00, 1'b1);
    x = dec_tid;
    held = dec_data;
    step(2'b11, 1'b0, 1'b0, 2'b00, 1'b1);
    chk(dec_data === held, "R7 slot held during stall", 64'(dec_data[IW-1:0]), 64'(held[IW-1:0]));
    chk(dec_valid === 4'hF, "R7 valid held during stall", 64'(dec_valid), 64'hF);
    step(2'b11, 1'b1, x, x ? 2'b10 : 2'b01, 1'b1);
    step(2'b11, 1'b0, 1'b0, 2'b00, 1'b1);
    chk(dec_valid === '0, "R8 flushed owner clears slot", 64'(dec_valid), 64'h0);
    chk(thr_nonempty[x] === 1'b0, "R8 flushed thread empty", 64'(thr_nonempty[x]), 64'h0);
    chk(thr_nonempty[!x] === 1'b1, "R8 other thread kept", 64'(thr_nonempty[!x]), 64'h1);
    step(2'b11, 1'b0, 1'b0, 2'b00, 1'b0);
    step(2'b11, 1'b0, 1'b0, 2'b00, 1'b0);
    chk(dec_tid === !x, "R8 other thread still readable", 64'(dec_tid), 64'(!x));

    // Random traffic against the model
    begin
      logic [1:0] act;
      act = 2'b11;
      for (int k = 0; k < 4000; k++) begin
        logic [1:0] fl;
        if (k % 50 == 0) begin
          case ($urandom % 5)
            0: act = 2'b01;
            1: act = 2'b10;
            2: act = 2'b00;
            default: act = 2'b11;
          endcase
        end
        fl[0] = ($urandom % 40) == 0;
        fl[1] = ($urandom % 40) == 0;
        step(act, ($urandom % 10) < 7, 1'($urandom % 2), fl, ($urandom % 10) < 3);
      end
    end
    step(2'b11, 1'b0, 1'b0, 2'b00, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule